// File: doc/BRIEF.md
# Token-Ring Chained FIFO Slice

This block is a synchronous FIFO slice. It works alone or as one link in a ring of identical slices that act together as one deeper queue. Every slice sees the same write strobe, read strobe and write data. Each slice may hold a write token and a read token, and only the holder of a token responds to the matching strobe. When a slice writes into its last location, it hands the write token to the next slice in the ring. When it reads from its last location, it hands over the read token in the same way. The handover is one pulse wire plus one tag wire that says which token is moving.

The wrapper builds a ring of `SLICES` slices. Slice 0 is the first-load slice, and the last slice feeds back into slice 0. The wrapper merges the read outputs of all slices. It reports full only when every slice is full, and empty only when every slice is empty. The chain therefore stores `SLICES*DEPTH` words. When `SLICES` is 1, the single slice runs in standalone mode: it keeps both tokens for good, never pulses its expansion output, and reports a half-full flag.

Top module: `fifo_chain_top`

## Requirements
- R1: After reset, `empty` is 1, and `full`, `half_full` and `rd_valid` are 0.
- R2: Words leave in exactly the order they were accepted, including when the stream crosses from one slice to the next several times.
- R3: `full` rises after exactly `SLICES*DEPTH` accepted writes with no reads. A write strobe while `full` is 1 stores nothing: draining afterwards returns only the words accepted before it.
- R4: `empty` is 1 once every stored word has been read. A read strobe while `empty` is 1 leaves `rd_valid` at 0 in the following cycle. `full` and `empty` are never 1 together.
- R5: A read accepted at a clock edge gives `rd_valid`=1, with the word on `rd_data`, in the cycle after that edge. With no accepted read, `rd_valid` is 0 in the next cycle.
- R6: In a chain, exactly one slice holds the write token and exactly one holds the read token. After reset, the first-load slice (slice 0) holds both.
- R7: A slice that writes its last location sends one expansion pulse tagged write (tag 0) and gives up its write token. A slice that reads its last location sends one pulse tagged read (tag 1) and gives up its read token. A slice never sends both in the same cycle.
- R8: With `SLICES`=1, the FIFO holds `DEPTH` words. `half_full` is 1 exactly while more than `DEPTH/2` words are stored, and the expansion output stays idle.
- R9: In a chain, `half_full` stays 0 whatever the fill level.
- R10: A cycle with an accepted write and an accepted read leaves the stored word count unchanged and keeps the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, shared by all slices |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe, shared by all slices |
| rd_data | output | WIDTH | Word read, valid while `rd_valid` is 1 |
| rd_valid | output | 1 | A word was read at the previous edge |
| full | output | 1 | Every slice is full |
| empty | output | 1 | Every slice is empty |
| half_full | output | 1 | More than half full (standalone only) |

## Verification
The assertions check these properties on every cycle:
- each token is held by exactly one slice;
- a slice never sends a write-wrap pulse and a read-wrap pulse together, and it drops the token it sent;
- per-slice counts stay within bounds, and a full slice stays full until it is read;
- the half-full flag is silent in a chain;
- `rd_valid` only follows an accepted read.

Only the bench's scenarios can show three further things:
- the full FIFO order across several slice handovers, checked against a reference queue;
- the exact write count at which the composite full flag rises, and that a write while full is dropped;
- the standalone half-full threshold.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  typedef enum logic {
    WRAP_WR = 1'b0,
    WRAP_RD = 1'b1
  } wrap_tag_e;

  function automatic int half_level(input int depth);
    return depth / 2;
  endfunction
endpackage

// File: rtl/chain_slice_ram.sv
module chain_slice_ram #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/chain_token.sv
module chain_token (
  input  logic clk,
  input  logic rst_n,
  input  logic solo_mode,
  input  logic start_held,
  input  logic grant,
  input  logic give_up,
  output logic held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held <= start_held | solo_mode;
    else if (solo_mode) held <= 1'b1;
    else if (grant)     held <= 1'b1;
    else if (give_up)   held <= 1'b0;
  end
endmodule

// File: rtl/chain_slice.sv
module chain_slice
  import fifo_chain_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             solo_mode,
  input  logic             first_load_n,
  input  logic             xin_pulse,
  input  logic             xin_tag,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full,
  output logic             empty,
  output logic             half_full,
  output logic             xout_pulse,
  output logic             xout_tag,
  output logic             has_wr_tok,
  output logic             has_rd_tok
);
  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic wr_fire, rd_fire, wr_pass, rd_pass, grant_wr, grant_rd;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign wr_fire = has_wr_tok && wr_en && !full;
  assign rd_fire = has_rd_tok && rd_en && !empty;
  assign wr_pass = wr_fire && (wptr == LAST) && !solo_mode;
  assign rd_pass = rd_fire && (rptr == LAST) && !solo_mode;
  assign grant_wr = xin_pulse && !solo_mode && (wrap_tag_e'(xin_tag) == WRAP_WR);
  assign grant_rd = xin_pulse && !solo_mode && (wrap_tag_e'(xin_tag) == WRAP_RD);
  assign xout_pulse = wr_pass || rd_pass;
  assign xout_tag   = rd_pass ? logic'(WRAP_RD) : logic'(WRAP_WR);
  assign half_full  = solo_mode && (int'(cnt) > half_level(DEPTH));

  chain_token u_wr_tok (
    .clk(clk), .rst_n(rst_n), .solo_mode(solo_mode), .start_held(!first_load_n),
    .grant(grant_wr), .give_up(wr_pass), .held(has_wr_tok)
  );
  chain_token u_rd_tok (
    .clk(clk), .rst_n(rst_n), .solo_mode(solo_mode), .start_held(!first_load_n),
    .grant(grant_rd), .give_up(rd_pass), .held(has_rd_tok)
  );

  chain_slice_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(wptr), .wdata(wr_data),
    .re(rd_fire), .raddr(rptr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_fire) wptr <= bump(wptr);
      if (rd_fire) rptr <= bump(rptr);
      cnt      <= cnt + CW'(wr_fire) - CW'(rd_fire);
      rd_valid <= rd_fire;
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);
  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !(rd_en && has_rd_tok)) |=> full);
  assert_no_dual_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_pass && rd_pass));
  assert_wr_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pass |=> !has_wr_tok);
  assert_rd_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pass |=> !has_rd_tok);
  assert_solo_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    solo_mode |-> !xout_pulse);
  assert_half_chain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !solo_mode |-> !half_full);
endmodule

// File: rtl/fifo_chain_top.sv
module fifo_chain_top #(
  parameter int WIDTH  = 8,
  parameter int DEPTH  = 8,
  parameter int SLICES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid,
  output logic             full,
  output logic             empty,
  output logic             half_full
);
  localparam logic SOLO = (SLICES == 1);

  logic [WIDTH-1:0] s_data [SLICES];
  logic [SLICES-1:0] s_valid, s_full, s_empty, s_half, s_xo, s_xo_tag, wr_tok_v, rd_tok_v;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    localparam int PREV = (i == 0) ? SLICES - 1 : i - 1;
    chain_slice #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_slice (
      .clk(clk), .rst_n(rst_n), .solo_mode(SOLO),
      .first_load_n((i == 0) ? 1'b0 : 1'b1),
      .xin_pulse(s_xo[PREV]), .xin_tag(s_xo_tag[PREV]),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(s_data[i]), .rd_valid(s_valid[i]),
      .full(s_full[i]), .empty(s_empty[i]), .half_full(s_half[i]),
      .xout_pulse(s_xo[i]), .xout_tag(s_xo_tag[i]),
      .has_wr_tok(wr_tok_v[i]), .has_rd_tok(rd_tok_v[i])
    );
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < SLICES; i++)
      if (s_valid[i]) rd_data = rd_data | s_data[i];
  end

  assign rd_valid  = |s_valid;
  assign full      = &s_full;
  assign empty     = &s_empty;
  assign half_full = s_half[0];

  assert_one_wr_tok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_tok_v) == 1);
  assert_one_rd_tok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rd_tok_v) == 1);
  assert_one_reader_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_valid));
  assert_flag_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  assert_rd_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_en) && !$past(empty)));
endmodule

// File: tb/fifo_chain_top_bench.sv
module fifo_chain_top_bench;
  localparam int W = 8, D = 8, N = 3, CAP = D * N;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic c_we = 0, c_re = 0, s_we = 0, s_re = 0;
  logic [W-1:0] c_wd = 0, s_wd = 0, c_rd, s_rd;
  logic c_rv, c_full, c_empty, c_half, s_rv, s_full, s_empty, s_half;

  fifo_chain_top #(.WIDTH(W), .DEPTH(D), .SLICES(N)) u_fifo_chain_top (
    .clk(clk), .rst_n(rst_n), .wr_en(c_we), .wr_data(c_wd), .rd_en(c_re),
    .rd_data(c_rd), .rd_valid(c_rv), .full(c_full), .empty(c_empty), .half_full(c_half));
  fifo_chain_top #(.WIDTH(W), .DEPTH(D), .SLICES(1)) u_fifo_chain_top_solo (
    .clk(clk), .rst_n(rst_n), .wr_en(s_we), .wr_data(s_wd), .rd_en(s_re),
    .rd_data(s_rd), .rd_valid(s_rv), .full(s_full), .empty(s_empty), .half_full(s_half));

  int tests = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] cq[$], sq[$];
  logic [W-1:0] seed = 8'h11;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input bit solo);
    @(negedge clk);
    seed = seed * 8'd5 + 8'd3;
    if (solo) begin s_we = 1; s_wd = seed; if (!s_full) sq.push_back(seed); end
    else      begin c_we = 1; c_wd = seed; if (!c_full) cq.push_back(seed); end
    @(negedge clk);
    c_we = 0; s_we = 0;
  endtask

  task automatic pull(input bit solo, input string req);
    logic exp_v;
    logic [W-1:0] exp_d;
    @(negedge clk);
    exp_v = solo ? !s_empty : !c_empty;
    exp_d = '0;
    if (exp_v) exp_d = solo ? sq.pop_front() : cq.pop_front();
    if (solo) s_re = 1; else c_re = 1;
    @(negedge clk);
    s_re = 0; c_re = 0;
    chk({req, " valid"}, solo ? s_rv : c_rv, exp_v);
    if (exp_v) chk({req, " data"}, solo ? s_rd : c_rd, exp_d);
  endtask

  task automatic t_reset;
    chk("R1 empty", c_empty, 1); chk("R1 full", c_full, 0);
    chk("R1 valid", c_rv, 0);    chk("R1 half", c_half, 0);
    chk("R1 solo empty", s_empty, 1); chk("R1 solo half", s_half, 0);
  endtask

  task automatic t_fill_chain;
    for (int i = 0; i < CAP - 1; i++) push(0);
    chk("R3 not full at CAP-1", c_full, 0);
    push(0);
    chk("R3 full at CAP", c_full, 1);
    chk("R9 half in chain", c_half, 0);
    push(0);
    chk("R3 still full", c_full, 1);
    chk("R3 queue size", cq.size(), CAP);
    for (int i = 0; i < CAP; i++) pull(0, "R2 R6 R7 drain");
    chk("R4 empty after drain", c_empty, 1);
    pull(0, "R4 read when empty");
    @(negedge clk);
    chk("R5 valid idle", c_rv, 0);
  endtask

  task automatic t_stream;
    logic exp_v;
    logic [W-1:0] exp_d;
    for (int i = 0; i < 5; i++) push(0);
    exp_v = 0; exp_d = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R10 stream valid", c_rv, exp_v);
        chk("R2 stream data", c_rd, exp_d);
      end
      seed = seed * 8'd5 + 8'd3;
      c_we = 1; c_wd = seed; c_re = 1;
      exp_v = 1; exp_d = cq.pop_front();
      cq.push_back(seed);
    end
    @(negedge clk);
    c_we = 0; c_re = 0;
    chk("R10 last valid", c_rv, 1);
    chk("R2 last data", c_rd, exp_d);
    for (int i = 0; i < 5; i++) pull(0, "R10 tail");
    chk("R10 count kept", c_empty, 1);
  endtask

  task automatic t_solo;
    for (int i = 0; i < D / 2; i++) push(1);
    chk("R8 half at D/2", s_half, 0);
    push(1);
    chk("R8 half above D/2", s_half, 1);
    for (int i = D / 2 + 1; i < D; i++) push(1);
    chk("R8 full at D", s_full, 1);
    push(1);
    for (int i = 0; i < D; i++) pull(1, "R8 solo drain");
    chk("R8 empty", s_empty, 1);
    chk("R8 half clear", s_half, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_fill_chain;
    t_stream;
    t_solo;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule